// File: doc/BRIEF.md
# Key-Protected Debug Command Unit

This block sits behind a debug port and offers two write-only registers on a simple 32-bit write bus. One holds a 32-bit unlock key and the other holds commands. A command write is carried out only after the exact unlock key has been written. Each accepted command uses up the key, so the next command needs a fresh key write.

Two commands exist. The reset command raises a one-cycle system reset request. The erase command starts a sequencer that walks three erase steps in a fixed order through request/acknowledge handshakes with the memory controller. The main flash block is erased first, then SRAM is cleared, and then the lock page is erased. Erasing the lock page also clears the user data page's lock word. The user data page contents are never erased. When the last step has been acknowledged, a sticky status output shows that debug access will be open after the next reset. A busy flag covers the whole sequence, and any command written while it is high is dropped.

Top module: `dbg_cmd_unit`

## Requirements
- R1: The command register decodes at byte offset 0x00 and the key register at 0x04. Writes to any other offset change nothing, and they do not disarm a key that is already armed.
- R2: Writing 32'hCFACC118 to the key register arms the unit. A command write while the unit is not armed has no effect.
- R3: After reset the unit is disarmed, and `sys_rst_req`, `busy`, `step_req` and `dbg_unlocked` are all low. A key written before a reset does not survive it.
- R4: Writing any other value to the key register disarms the unit. Every write to the command register also disarms it, so one key write allows exactly one command.
- R5: An armed write with data bit 1 set (and bit 0 clear) raises `sys_rst_req` for exactly one cycle, in the cycle after the write.
- R6: An armed write with data bit 0 set starts the erase. `step_req` goes one-hot in this order: bit 0 (main flash), then bit 1 (SRAM), then bit 2 (lock page, which also clears the user page lock word). No other request is issued. Each request holds until its own acknowledge bit is sampled high, and the next request rises in the following cycle.
- R7: `busy` is high from the cycle after an accepted erase command until the edge that samples the last acknowledge. Any command written while `busy` is high is dropped.
- R8: `dbg_unlocked` rises at the edge that samples the lock-page acknowledge and stays high until reset.
- R9: Data bits 31:2 of a command write are ignored.
- R10: If bits 0 and 1 are both set in one accepted write, the erase runs first. The one-cycle reset request then appears in the same cycle that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| step_ack | input | 3 | Per-step erase acknowledge from the memory controller |
| step_req | output | 3 | Per-step erase request (bit 0 main, 1 SRAM, 2 lock page) |
| busy | output | 1 | Erase sequence in progress |
| sys_rst_req | output | 1 | One-cycle system reset request |
| dbg_unlocked | output | 1 | Erase finished; debug opens after next reset |

## Verification
The checker assumes that the memory controller acknowledges only the step whose request is high, and only for one cycle at a time. The checker's hold and ordering properties rely on that assumption. The bench responder keeps to it: it raises at most the currently requested bit, after a programmable delay, for a single cycle. The bus writes are single-cycle strobes with idle cycles between them. This matches the one-write-per-cycle assumption behind the single-cycle accept decode.

// File: rtl/dcu_pkg.sv
package dcu_pkg;

   // Unlock key and command bit positions (the command bits are decoded by position)
   localparam logic [31:0] DCU_UNLOCK_KEY = 32'hCFACC118;
   localparam int unsigned DCU_KEY_W      = 32;
   localparam int unsigned DCU_BIT_ERASE  = 0;
   localparam int unsigned DCU_BIT_RESET  = 1;

   // Erase order: index 0 main flash, 1 SRAM, 2 lock page (always last)
   localparam int unsigned DCU_N_STEPS    = 3;
   localparam int unsigned DCU_STEP_MAIN  = 0;
   localparam int unsigned DCU_STEP_SRAM  = 1;
   localparam int unsigned DCU_STEP_LOCK  = 2;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'b00,
      CMD_RESET = 2'b01,
      CMD_ERASE = 2'b10,
      CMD_BOTH  = 2'b11
   } dcu_cmd_e;

endpackage

// File: rtl/dcu_reg_decode.sv
module dcu_reg_decode
   import dcu_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CMD_OFS = 0,
   parameter int unsigned KEY_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output dcu_cmd_e          cmd_accept
);

   localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);
   localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFS);

   if (DATA_W < DCU_KEY_W) begin : g_chk_w
      $error("dcu_reg_decode: DATA_W must hold the 32-bit key");
   end
   if (CMD_OFS == KEY_OFS) begin : g_chk_ofs
      $error("dcu_reg_decode: register offsets must differ");
   end

   logic hit_cmd;
   logic hit_key;
   logic key_match;
   logic armed_q;

   assign hit_cmd = wr_en && (wr_addr == CMD_A);
   assign hit_key = wr_en && (wr_addr == KEY_A);

   // Wider buses: the upper bits must be zero for a key match
   if (DATA_W == DCU_KEY_W) begin : g_key_exact
      assign key_match = (wr_data == DCU_UNLOCK_KEY);
   end else begin : g_key_wide
      assign key_match = (wr_data[DCU_KEY_W-1:0] == DCU_UNLOCK_KEY)
                      && (wr_data[DATA_W-1:DCU_KEY_W] == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (hit_key) begin
         armed_q <= key_match;
      end else if (hit_cmd) begin
         armed_q <= 1'b0;
      end
   end

   // Only the two low command bits matter; the rest are reserved
   always_comb begin
      cmd_accept = CMD_NONE;
      if (hit_cmd && armed_q && !busy) begin
         cmd_accept = dcu_cmd_e'({wr_data[DCU_BIT_ERASE], wr_data[DCU_BIT_RESET]});
      end
   end

endmodule

// File: rtl/dcu_erase_seq.sv
module dcu_erase_seq #(
   parameter int unsigned N_STEPS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [N_STEPS-1:0] step_ack,
   output logic [N_STEPS-1:0] step_req,
   output logic               busy,
   output logic               finish,
   output logic               unlocked
);

   localparam int unsigned IDX_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STEPS - 1);

   if (N_STEPS < 1) begin : g_chk_n
      $error("dcu_erase_seq: at least one step is required");
   end

   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic             hs;

   for (genvar i = 0; i < N_STEPS; i++) begin : g_req
      assign step_req[i] = active_q && (idx_q == IDX_W'(i));
   end

   assign hs     = |(step_req & step_ack);
   assign finish = hs && (idx_q == LAST_IDX);
   assign busy   = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         unlocked <= 1'b0;
      end else begin
         if (!active_q) begin
            if (start) begin
               active_q <= 1'b1;
               idx_q    <= '0;
            end
         end else if (hs) begin
            if (idx_q == LAST_IDX) begin
               active_q <= 1'b0;
               idx_q    <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
         if (finish) begin
            unlocked <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dcu_reset_pulse.sv
module dcu_reset_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_now,
   input  logic defer,
   input  logic release_i,
   output logic rst_req
);

   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fire_now || (pend_q && release_i);
         if (defer) begin
            pend_q <= 1'b1;
         end else if (release_i) begin
            pend_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dbg_cmd_unit.sv
module dbg_cmd_unit
   import dcu_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CMD_OFS = 0,
   parameter int unsigned KEY_OFS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [DCU_N_STEPS-1:0] step_ack,
   output logic [DCU_N_STEPS-1:0] step_req,
   output logic                   busy,
   output logic                   sys_rst_req,
   output logic                   dbg_unlocked
);

   if (DCU_STEP_LOCK != DCU_N_STEPS - 1) begin : g_chk_order
      $error("dbg_cmd_unit: lock page must be the final step");
   end

   dcu_cmd_e cmd_accept;
   logic     seq_finish;
   logic     go_erase;
   logic     go_reset;

   dcu_reg_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CMD_OFS (CMD_OFS),
      .KEY_OFS (KEY_OFS)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .busy       (busy),
      .cmd_accept (cmd_accept)
   );

   assign go_erase = (cmd_accept == CMD_ERASE) || (cmd_accept == CMD_BOTH);
   assign go_reset = (cmd_accept == CMD_RESET);

   dcu_erase_seq #(
      .N_STEPS (DCU_N_STEPS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (go_erase),
      .step_ack (step_ack),
      .step_req (step_req),
      .busy     (busy),
      .finish   (seq_finish),
      .unlocked (dbg_unlocked)
   );

   dcu_reset_pulse u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_now  (go_reset),
      .defer     (cmd_accept == CMD_BOTH),
      .release_i (seq_finish),
      .rst_req   (sys_rst_req)
   );

endmodule

// File: rtl/dcu_checker.sv
module dcu_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] step_ack,
   input logic [2:0] step_req,
   input logic       busy,
   input logic       sys_rst_req,
   input logic       dbg_unlocked
);

   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> !sys_rst_req);                                   // R5

   AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(step_req));                                             // R6

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((step_req != 3'b000) && ((step_req & step_ack) == 3'b000))
      |=> (step_req == $past(step_req)));                              // R6

   AST_START_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (step_req == 3'b001));                           // R6

   AST_ORDER_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_req[1]) |-> $past(step_req[0] && step_ack[0]));       // R6

   AST_ORDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_req[2]) |-> $past(step_req[1] && step_ack[1]));       // R6

   AST_REQ_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req != 3'b000) |-> busy);                                  // R7

   AST_RST_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> !busy);                                          // R10

   AST_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_unlocked) |-> $past(step_req[2] && step_ack[2]));      // R8

   AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_unlocked |=> dbg_unlocked);                                  // R8

endmodule

bind dbg_cmd_unit dcu_checker u_dcu_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .step_ack     (step_ack),
   .step_req     (step_req),
   .busy         (busy),
   .sys_rst_req  (sys_rst_req),
   .dbg_unlocked (dbg_unlocked)
);

// File: tb/dbg_cmd_unit_bench.sv
module dbg_cmd_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] KEY = 32'hCFACC118;

   // Vector: {do_key, key, addr, data, exp_rst, exp_erase}
   localparam int NVEC = 9;
   localparam logic [74:0] VEC [NVEC] = '{
      {1'b1, KEY,          8'h00, 32'h0000_0002, 1'b1, 1'b0}, // R5
      {1'b0, 32'h0,        8'h00, 32'h0000_0002, 1'b0, 1'b0}, // R4 key used
      {1'b1, 32'h12345678, 8'h00, 32'h0000_0002, 1'b0, 1'b0}, // R2 wrong key
      {1'b1, KEY,          8'h00, 32'h0000_0001, 1'b0, 1'b1}, // R6
      {1'b1, KEY,          8'h00, 32'hFFFF_FFFC, 1'b0, 1'b0}, // R9
      {1'b1, KEY,          8'h08, 32'h0000_0002, 1'b0, 1'b0}, // R1 other offset
      {1'b0, 32'h0,        8'h00, 32'h0000_0002, 1'b1, 1'b0}, // R1 still armed
      {1'b1, KEY,          8'h00, 32'h0000_0003, 1'b1, 1'b1}, // R10
      {1'b1, KEY,          8'h00, 32'hFFFF_FFFE, 1'b1, 1'b0}  // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  step_ack;
   logic [2:0]  step_req;
   logic        busy;
   logic        sys_rst_req;
   logic        dbg_unlocked;

   int checks = 0;
   int failures = 0;
   int ack_lat = 1;
   int ack_cnt = 0;
   bit finished = 0;

   int cyc = 0;
   int order_log [8];
   int n_log = 0;
   int rst_count = 0;
   int rst_cyc = -1;
   int fall_cyc = -2;
   logic [2:0] prev_req = '0;
   logic prev_busy = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_cmd_unit u_dbg_cmd_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .step_ack     (step_ack),
      .step_req     (step_req),
      .busy         (busy),
      .sys_rst_req  (sys_rst_req),
      .dbg_unlocked (dbg_unlocked)
   );

   // Memory controller model: one-cycle ack of the requested step after ack_lat cycles
   always @(posedge clk) begin
      if (!rst_n) begin
         step_ack <= '0;
         ack_cnt  <= 0;
      end else begin
         step_ack <= '0;
         if (step_req != 3'b000 && step_ack == 3'b000) begin
            if (ack_cnt >= ack_lat) begin
               step_ack <= step_req;
               ack_cnt  <= 0;
            end else begin
               ack_cnt <= ack_cnt + 1;
            end
         end
      end
   end

   // Observer: order of request rises, reset pulses, busy falls
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (step_req != prev_req && step_req != 3'b000 && n_log < 8) begin
         order_log[n_log] = (step_req == 3'b001) ? 0 :
                            (step_req == 3'b010) ? 1 :
                            (step_req == 3'b100) ? 2 : 9;
         n_log = n_log + 1;
      end
      if (sys_rst_req) begin
         rst_count = rst_count + 1;
         rst_cyc   = cyc;
      end
      if (prev_busy && !busy) fall_cyc = cyc;
      prev_req  = step_req;
      prev_busy = busy;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 400 && busy; k++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int base;
      do_reset();
      @(negedge clk);
      // R3: reset state
      chk("R3", "sys_rst_req", 32'(sys_rst_req), 0);
      chk("R3", "busy", 32'(busy), 0);
      chk("R3", "step_req", 32'(step_req), 0);
      chk("R3", "dbg_unlocked", 32'(dbg_unlocked), 0);
      bus_wr(8'h00, 32'h3);
      chk("R3", "cmd without key after reset", 32'(sys_rst_req | busy), 0);

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         logic        do_key;
         logic [31:0] kval;
         logic [7:0]  addr;
         logic [31:0] data;
         logic        exp_rst;
         logic        exp_er;
         {do_key, kval, addr, data, exp_rst, exp_er} = VEC[v];
         if (do_key) bus_wr(8'h04, kval);
         n_log = 0;
         base  = rst_count;
         bus_wr(addr, data);
         if (exp_er) begin
            chk("R7", $sformatf("vec%0d busy", v), 32'(busy), 1);
            chk("R6", $sformatf("vec%0d first req", v), 32'(step_req), 32'h1);
            chk("R10", $sformatf("vec%0d no early reset", v), 32'(sys_rst_req), 0);
            wait_idle();
            @(negedge clk);
            chk("R6", $sformatf("vec%0d step count", v), 32'(n_log), 3);
            chk("R6", $sformatf("vec%0d order", v),
                {order_log[0][7:0], order_log[1][7:0], order_log[2][7:0]}, 32'h000102);
            chk("R8", $sformatf("vec%0d unlocked", v), 32'(dbg_unlocked), 1);
            chk("R10", $sformatf("vec%0d reset count", v), 32'(rst_count - base),
                exp_rst ? 32'd1 : 32'd0);
            if (exp_rst) chk("R10", $sformatf("vec%0d reset with busy fall", v),
                             32'(rst_cyc), 32'(fall_cyc));
         end else begin
            chk("R5", $sformatf("vec%0d reset pulse", v), 32'(sys_rst_req), 32'(exp_rst));
            chk("R7", $sformatf("vec%0d busy", v), 32'(busy), 0);
            @(negedge clk);
            chk("R5", $sformatf("vec%0d pulse width", v), 32'(sys_rst_req), 0);
            chk("R5", $sformatf("vec%0d pulse count", v), 32'(rst_count - base),
                exp_rst ? 32'd1 : 32'd0);
         end
      end

      // R4: a wrong key after a good one disarms
      base = rst_count;
      bus_wr(8'h04, KEY);
      bus_wr(8'h04, KEY ^ 32'h1);
      bus_wr(8'h00, 32'h2);
      @(negedge clk);
      chk("R4", "wrong key disarms", 32'(rst_count - base), 0);

      // R6/R7: slow controller; request holds; commands dropped while busy
      ack_lat = 30;
      bus_wr(8'h04, KEY);
      bus_wr(8'h00, 32'h1);
      repeat (3) @(negedge clk);
      chk("R6", "request held without ack", 32'(step_req), 32'h1);
      base = rst_count;
      bus_wr(8'h04, KEY);
      bus_wr(8'h00, 32'h2);
      chk("R7", "busy while stalled", 32'(busy), 1);
      wait_idle();
      repeat (2) @(negedge clk);
      chk("R7", "command during busy dropped", 32'(rst_count - base), 0);
      bus_wr(8'h00, 32'h2);
      @(negedge clk);
      chk("R4", "dropped command still used key", 32'(rst_count - base), 0);
      ack_lat = 1;

      // R8/R3: reset clears the status; a key before reset is lost
      bus_wr(8'h04, KEY);
      do_reset();
      @(negedge clk);
      chk("R8", "unlocked cleared by reset", 32'(dbg_unlocked), 0);
      base = rst_count;
      bus_wr(8'h00, 32'h2);
      @(negedge clk);
      chk("R3", "key lost across reset", 32'(rst_count - base), 0);

      finish_run();
   end

endmodule